// File: doc/BRIEF.md
# Host-to-SRAM Access Sequencer with Priority Arbitration

This block lets a local processor, whose bus is asynchronous in style, share one synchronous SRAM with a set of internal memory requesters. A processor access starts when chip-select and address-strobe are both seen low on a clock edge. On that edge the block captures the transfer direction, the bank and word select, and the byte-lane enables. It then asks a fixed-priority arbiter for the memory.

Once the processor wins, the block spends one turnaround cycle with the transceiver enable active and no data. It then runs one or more data cycles with ready low. The processor keeps the memory until it marks a data beat as the last one. A single recovery cycle follows, which the arbiter uses to serve internal requesters. Each internal requester is granted for exactly one cycle and does a single-cycle SRAM access in that cycle. The arbiter and a small byte-writable SRAM are part of the block.

Top module: `host_sram_sequencer`

## Requirements
- R1: After reset, rdy_n and xcvr_en_n are high and int_gnt is all zero.
- R2: An access begins on a rising edge, while the block is idle, where cs_n and as_n are both low. That edge captures wr_sel (1 = write), bank_sel, word_sel and be_n. Changes to these five inputs after that edge have no effect on the access.
- R3: The cycle after the capture is an arbitration cycle. The arbiter uses fixed priority, and lower slot numbers win. The processor sits at slot HOST_RANK. Internal requester j takes slot j when j < HOST_RANK and slot j+1 otherwise. The winner's grant begins in the next cycle. A losing processor stays pending and competes again in each following cycle.
- R4: The first cycle after the processor wins has xcvr_en_n low and rdy_n high. rdy_n goes low in the next cycle. If the capture edge ends cycle 1 and nothing contends, rdy_n is first low in cycle 4, and it is never low earlier.
- R5: While rdy_n is low on a read, rdata equals the SRAM word at address {bank, word}, with the bank in the high bits. be_n has no effect on reads.
- R6: On a write, each rising edge with rdy_n low stores byte lane k (wdata[8k+7:8k]) only when the captured be_n[k] is 0.
- R7: A data beat with blast_n high is followed by another data beat with rdy_n low. Each new beat uses word select plus one, wrapping modulo 4.
- R8: The cycle after the beat with blast_n low has rdy_n and xcvr_en_n high and is an arbitration cycle. An internal request pending in that cycle is granted in the cycle after it.
- R9: No int_gnt bit is high from the processor's turnaround cycle up to and including its last data beat.
- R10: An int_gnt bit stays high for one cycle only. In that cycle int_rdata is the SRAM word at that requester's int_addr. If its int_we is 1, the whole int_wdata word is stored at that rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Processor chip select, active low |
| as_n | input | 1 | Processor address strobe, active low |
| wr_sel | input | 1 | Direction: 1 write, 0 read |
| bank_sel | input | BANK_W | Bank select (high address bits) |
| word_sel | input | WORD_W | Word select (low address bits) |
| be_n | input | DATA_W/8 | Byte-lane enables, active low |
| wdata | input | DATA_W | Processor write data |
| blast_n | input | 1 | Last-beat flag, active low |
| rdata | output | DATA_W | Processor read data |
| rdy_n | output | 1 | Ready, active low |
| xcvr_en_n | output | 1 | Data/address transceiver enable, active low |
| int_req | input | N_INT | Internal request per requester |
| int_we | input | N_INT | Internal write flag per requester |
| int_addr | input | N_INT*(BANK_W+WORD_W) | Internal address, requester j in slice j |
| int_wdata | input | N_INT*DATA_W | Internal write data, requester j in slice j |
| int_gnt | output | N_INT | One-cycle grant per requester |
| int_rdata | output | DATA_W | Read data for the granted internal requester |

## Verification
The bench measures ready latency from the capture edge. It does this both with no contention and with a higher-priority requester that arrives in the arbitration cycle. A design that skipped the turnaround or the arbitration cycle would assert ready a cycle early. A design that ignored priority would show the wrong latency for either the processor or the internal requester.

Internal requests are raised during the turnaround and during a burst. A design that let another requester interrupt the burst, or that did not arbitrate in the recovery cycle, would raise int_gnt at the wrong time. The bench also checks several other cases:
- Bank, word, direction and byte enables are scrambled right after capture, which exposes a design that samples them late.
- A burst starts at word 3, so a design without wrap-around would write the wrong addresses.
- A partial-lane write is done, and a read is issued with all byte enables inactive, to catch a design that gates reads by lane.

// File: rtl/hss_pkg.sv
package hss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARB   = 3'd1,
        ST_TURN  = 3'd2,
        ST_DATA  = 3'd3,
        ST_RECOV = 3'd4
    } hst_e;

endpackage

// File: rtl/hss_host_fsm.sv
module hss_host_fsm
    import hss_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int WORD_W = 2,
    parameter int LANES  = 4,
    localparam int AW    = BANK_W + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              as_n,
    input  logic              wr_sel,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [WORD_W-1:0] word_sel,
    input  logic [LANES-1:0]  be_n,
    input  logic              blast_n,
    input  logic              host_win,
    output logic              host_req,
    output logic              data_cyc,
    output logic              busy,
    output logic              rdy_n,
    output logic              xcvr_en_n,
    output logic [AW-1:0]     acc_addr,
    output logic              acc_we,
    output logic [LANES-1:0]  lane_en
);

    typedef struct packed {
        hst_e              st;
        logic              we;
        logic [BANK_W-1:0] bank;
        logic [WORD_W-1:0] word;
        logic [LANES-1:0]  lanes;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (!cs_n && !as_n) begin
                    ctx_d.st    = ST_ARB;
                    ctx_d.we    = wr_sel;
                    ctx_d.bank  = bank_sel;
                    ctx_d.word  = word_sel;
                    ctx_d.lanes = ~be_n;
                end
            end
            ST_ARB: begin
                if (host_win) ctx_d.st = ST_TURN;
            end
            ST_TURN: begin
                ctx_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (!blast_n) ctx_d.st   = ST_RECOV;
                else          ctx_d.word = ctx_q.word + 1'b1;
            end
            ST_RECOV: begin
                ctx_d.st = ST_IDLE;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign host_req  = (ctx_q.st == ST_ARB);
    assign data_cyc  = (ctx_q.st == ST_DATA);
    assign busy      = (ctx_q.st == ST_TURN) || (ctx_q.st == ST_DATA);
    assign rdy_n     = !data_cyc;
    assign xcvr_en_n = !busy;
    assign acc_addr  = {ctx_q.bank, ctx_q.word};
    assign acc_we    = ctx_q.we;
    assign lane_en   = ctx_q.lanes;

    // R4: ready is always preceded by a turnaround cycle without ready
    a_r4_turn_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(!xcvr_en_n && rdy_n));

    // R7: a non-final beat is followed by a beat at the next word
    a_r7_word_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && blast_n) |=>
        (!rdy_n && (acc_addr[WORD_W-1:0] == $past(acc_addr[WORD_W-1:0]) + 1'b1)));

    // R8: the beat after the last one is a recovery cycle
    a_r8_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && !blast_n) |=> (rdy_n && xcvr_en_n));

    // R2: captured bank does not move while the access owns the memory
    a_r2_bank_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(acc_addr[AW-1:WORD_W]));

endmodule

// File: rtl/hss_arbiter.sv
module hss_arbiter #(
    parameter int N_INT     = 2,
    parameter int HOST_RANK = 1,
    localparam int NR       = N_INT + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INT-1:0] int_req,
    input  logic             host_req,
    input  logic             hold,
    output logic             host_win,
    output logic [N_INT-1:0] int_gnt
);

    logic [N_INT-1:0] gnt_q, gnt_d, req_m;
    logic [NR-1:0]    slot, win;

    // a requester is not regranted in its own grant cycle
    assign req_m = int_req & ~gnt_q;

    for (genvar i = 0; i < NR; i++) begin : g_slot
        if (i < HOST_RANK) begin : g_lo
            assign slot[i] = req_m[i];
        end else if (i == HOST_RANK) begin : g_host
            assign slot[i] = host_req;
        end else begin : g_hi
            assign slot[i] = req_m[i-1];
        end
    end

    always_comb begin
        logic found;
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < NR; k++) begin
            if (slot[k] && !found) begin
                win[k] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign host_win = !hold && win[HOST_RANK];

    for (genvar j = 0; j < N_INT; j++) begin : g_map
        if (j < HOST_RANK) begin : g_lo
            assign gnt_d[j] = !hold && win[j];
        end else begin : g_hi
            assign gnt_d[j] = !hold && win[j+1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gnt_q <= '0;
        else        gnt_q <= gnt_d;
    end

    assign int_gnt = gnt_q;

    // R10: at most one internal grant, never two cycles in a row for one requester
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_q));

    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_q) |=> ((gnt_q & $past(gnt_q)) == '0));

    // R3: a processor win excludes an internal grant in the next cycle
    a_r3_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        host_win |=> (gnt_q == '0));

    // R9: nothing is granted while the processor owns the memory
    a_r9_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (gnt_q == '0));

endmodule

// File: rtl/hss_sram.sv
module hss_sram #(
    parameter int AW     = 4,
    parameter int DW     = 32,
    localparam int LANES = DW / 8,
    localparam int DEPTH = 2 ** AW
) (
    input  logic             clk,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] wr_lanes,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (wr_lanes[k]) mem[addr][8*k +: 8] <= wdata[8*k +: 8];
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/host_sram_sequencer.sv
module host_sram_sequencer #(
    parameter int N_INT     = 2,
    parameter int HOST_RANK = 1,
    parameter int BANK_W    = 2,
    parameter int WORD_W    = 2,
    parameter int DATA_W    = 32,
    localparam int AW       = BANK_W + WORD_W,
    localparam int LANES    = DATA_W / 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    as_n,
    input  logic                    wr_sel,
    input  logic [BANK_W-1:0]       bank_sel,
    input  logic [WORD_W-1:0]       word_sel,
    input  logic [LANES-1:0]        be_n,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    blast_n,
    output logic [DATA_W-1:0]       rdata,
    output logic                    rdy_n,
    output logic                    xcvr_en_n,
    input  logic [N_INT-1:0]        int_req,
    input  logic [N_INT-1:0]        int_we,
    input  logic [N_INT*AW-1:0]     int_addr,
    input  logic [N_INT*DATA_W-1:0] int_wdata,
    output logic [N_INT-1:0]        int_gnt,
    output logic [DATA_W-1:0]       int_rdata
);

    logic              host_req, host_win, data_cyc, busy, host_we;
    logic [AW-1:0]     host_addr;
    logic [LANES-1:0]  host_lanes;

    logic [AW-1:0]     sel_addr, mem_addr;
    logic              sel_we;
    logic [DATA_W-1:0] sel_wdata, mem_wdata, mem_rdata;
    logic [LANES-1:0]  mem_lanes;

    hss_host_fsm #(
        .BANK_W (BANK_W),
        .WORD_W (WORD_W),
        .LANES  (LANES)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .as_n      (as_n),
        .wr_sel    (wr_sel),
        .bank_sel  (bank_sel),
        .word_sel  (word_sel),
        .be_n      (be_n),
        .blast_n   (blast_n),
        .host_win  (host_win),
        .host_req  (host_req),
        .data_cyc  (data_cyc),
        .busy      (busy),
        .rdy_n     (rdy_n),
        .xcvr_en_n (xcvr_en_n),
        .acc_addr  (host_addr),
        .acc_we    (host_we),
        .lane_en   (host_lanes)
    );

    hss_arbiter #(
        .N_INT     (N_INT),
        .HOST_RANK (HOST_RANK)
    ) i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_req  (int_req),
        .host_req (host_req),
        .hold     (busy),
        .host_win (host_win),
        .int_gnt  (int_gnt)
    );

    always_comb begin
        sel_addr  = '0;
        sel_we    = 1'b0;
        sel_wdata = '0;
        for (int j = 0; j < N_INT; j++) begin
            if (int_gnt[j]) begin
                sel_addr  = int_addr[j*AW +: AW];
                sel_we    = int_we[j];
                sel_wdata = int_wdata[j*DATA_W +: DATA_W];
            end
        end
    end

    assign mem_addr  = data_cyc ? host_addr : sel_addr;
    assign mem_wdata = data_cyc ? wdata : sel_wdata;
    assign mem_lanes = data_cyc ? (host_we ? host_lanes : '0)
                                : (sel_we ? '1 : '0);

    hss_sram #(
        .AW (AW),
        .DW (DATA_W)
    ) i_sram (
        .clk      (clk),
        .addr     (mem_addr),
        .wr_lanes (mem_lanes),
        .wdata    (mem_wdata),
        .rdata    (mem_rdata)
    );

    assign rdata     = mem_rdata;
    assign int_rdata = mem_rdata;

    // R9: transceiver window and internal grants never overlap
    a_r9_no_int_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !xcvr_en_n |-> (int_gnt == '0));

    // R5: a processor read cycle never writes the SRAM
    a_r5_read_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && !host_we) |-> (mem_lanes == '0));

endmodule

// File: tb/test_host_sram_sequencer.sv
module test_host_sram_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, as_n = 1'b1, wr_sel = 1'b0, blast_n = 1'b1;
    logic [1:0]  bank_sel = '0, word_sel = '0;
    logic [3:0]  be_n = '1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, int_rdata;
    logic        rdy_n, xcvr_en_n;
    logic [1:0]  int_req = '0, int_we = '0, int_gnt;
    logic [7:0]  int_addr = '0;
    logic [63:0] int_wdata = '0;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] model [16];
    logic [31:0] exp_q [$];
    logic        rd_watch = 1'b0;

    always #4 clk = ~clk;

    host_sram_sequencer i_host_sram_sequencer (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .as_n (as_n),
        .wr_sel (wr_sel), .bank_sel (bank_sel), .word_sel (word_sel),
        .be_n (be_n), .wdata (wdata), .blast_n (blast_n),
        .rdata (rdata), .rdy_n (rdy_n), .xcvr_en_n (xcvr_en_n),
        .int_req (int_req), .int_we (int_we), .int_addr (int_addr),
        .int_wdata (int_wdata), .int_gnt (int_gnt), .int_rdata (int_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data on every ready cycle; R9 window check
    always @(negedge clk) begin
        if (rst_n && rd_watch && !rdy_n) begin
            if (exp_q.size() == 0) chk("R5 unexpected beat", 32'd1, 32'd0);
            else chk("R5 read data", rdata, exp_q.pop_front());
        end
        if (rst_n && !xcvr_en_n) chk("R9 grant in host window", {30'd0, int_gnt}, 32'd0);
    end

    task automatic host_access(input logic we, input logic [1:0] bk, input logic [1:0] wd,
                               input logic [3:0] ben, input int beats,
                               input logic [31:0] base, input int exp_lat);
        int lat;
        logic last_x;
        logic [3:0] a;
        if (!we) begin
            for (int b = 0; b < beats; b++) exp_q.push_back(model[{bk, 2'(wd + b)}]);
            rd_watch = 1'b1;
        end
        @(negedge clk);
        cs_n = 1'b0; as_n = 1'b0; wr_sel = we; bank_sel = bk; word_sel = wd; be_n = ben;
        @(posedge clk);
        @(negedge clk);
        // R2: scramble everything that was captured
        cs_n = 1'b1; as_n = 1'b1; wr_sel = !we; bank_sel = ~bk; word_sel = ~wd; be_n = ~ben;
        lat = 1;
        last_x = 1'b1;
        while (rdy_n && lat < 40) begin
            last_x = xcvr_en_n;
            @(negedge clk);
            lat++;
        end
        chk("R4 ready latency", lat, exp_lat);
        chk("R4 turnaround enable", {31'd0, last_x}, 32'd0);
        for (int b = 0; b < beats; b++) begin
            chk("R7 ready during beat", {31'd0, rdy_n}, 32'd0);
            chk("R4 enable during beat", {31'd0, xcvr_en_n}, 32'd0);
            blast_n = (b == beats - 1) ? 1'b0 : 1'b1;
            wdata = base + b;
            a = {bk, 2'(wd + b)};
            @(posedge clk);
            if (we) begin
                for (int k = 0; k < 4; k++)
                    if (!ben[k]) model[a][8*k +: 8] = wdata[8*k +: 8];
            end
            @(negedge clk);
        end
        blast_n = 1'b1;
        chk("R8 recovery ready", {31'd0, rdy_n}, 32'd1);
        chk("R8 recovery enable", {31'd0, xcvr_en_n}, 32'd1);
        rd_watch = 1'b0;
        chk("R5 all beats seen", exp_q.size(), 32'd0);
        @(negedge clk);
    endtask

    // raise internal request: sync=1 waits for the next capture edge then d negedges
    task automatic int_after(input int i, input logic sync, input int d, input logic we,
                             input logic [3:0] a, input logic [31:0] wd,
                             input int exp_wait, input string tag);
        int cnt;
        @(negedge clk);
        if (sync) begin
            @(posedge clk);
            repeat (d) @(negedge clk);
        end
        int_req[i] = 1'b1; int_we[i] = we; int_addr[i*4 +: 4] = a; int_wdata[i*32 +: 32] = wd;
        cnt = 0;
        do begin
            @(negedge clk);
            cnt++;
        end while (!int_gnt[i] && cnt < 60);
        chk(tag, cnt, exp_wait);
        chk("R10 one-hot grant", {30'd0, int_gnt}, 32'd1 << i);
        if (!we) chk("R10 internal read", int_rdata, model[a]);
        int_req[i] = 1'b0;
        if (we) begin
            @(posedge clk);
            model[a] = wd;
        end
        @(negedge clk);
        chk("R10 grant lasts one cycle", {30'd0, int_gnt}, 32'd0);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rdy_n", {31'd0, rdy_n}, 32'd1);
        chk("R1 xcvr_en_n", {31'd0, xcvr_en_n}, 32'd1);
        chk("R1 int_gnt", {30'd0, int_gnt}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R4 R6: single full-word write, then read with lanes off (R5)
        host_access(1'b1, 2'd1, 2'd2, 4'b0000, 1, 32'hA1B2C3D4, 3);
        host_access(1'b0, 2'd1, 2'd2, 4'b1111, 1, 32'h0, 3);
        // R6: lanes 0 and 2 only
        host_access(1'b1, 2'd1, 2'd2, 4'b1010, 1, 32'h11223344, 3);
        host_access(1'b0, 2'd1, 2'd2, 4'b0000, 1, 32'h0, 3);
        // R7: burst wrapping from word 3
        host_access(1'b1, 2'd2, 2'd3, 4'b0000, 4, 32'h5A5A0000, 3);
        host_access(1'b0, 2'd2, 2'd3, 4'b0000, 4, 32'h0, 3);
        // R10: internal write and read, then processor sees it
        int_after(0, 1'b0, 0, 1'b1, 4'd5, 32'hCAFE0005, 1, "R10 grant wait");
        int_after(1, 1'b0, 0, 1'b0, 4'd5, 32'h0, 1, "R10 grant wait");
        host_access(1'b0, 2'd1, 2'd1, 4'b0000, 1, 32'h0, 3);
        // R3: higher-priority requester in the arbitration cycle delays processor
        fork
            host_access(1'b0, 2'd2, 2'd0, 4'b0000, 1, 32'h0, 4);
            int_after(0, 1'b1, 1, 1'b1, 4'd14, 32'hBEEF000E, 1, "R3 high rank wins");
        join
        // R3 R8: lower-priority requester waits for recovery arbitration
        fork
            host_access(1'b0, 2'd2, 2'd1, 4'b0000, 1, 32'h0, 3);
            int_after(1, 1'b1, 1, 1'b0, 4'd5, 32'h0, 4, "R8 grant after recovery");
        join
        // R9: higher-priority request during a burst waits until recovery
        fork
            host_access(1'b0, 2'd2, 2'd1, 4'b0000, 3, 32'h0, 3);
            int_after(0, 1'b1, 2, 1'b1, 4'd13, 32'hF00D000D, 5, "R9 burst not cut");
        join
        host_access(1'b0, 2'd3, 2'd1, 4'b0000, 2, 32'h0, 3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule